// File: doc/BRIEF.md
# ALU with Condition Code Register

This block pairs an arithmetic and logic unit, whose data width is a parameter (eight bits by default), with an eight-bit condition code register. The register holds an interrupt mask and five status flags. On each accepted operation the unit produces its result combinationally from the operands and the current carry flag. At the next clock edge it writes the flags that the operation defines: overflow, half-carry, negative, zero and carry. The unit covers add, add-with-carry, subtract, subtract-with-borrow, three bitwise operations, two shifts and two rotates through carry.

The register also follows a small interrupt-entry sequence. A request is taken only while the mask is clear. The sequencer first spends one cycle in a SAVE state, where the unchanged register is presented for stacking. It then moves to a VECT state, in which the mask is already set, and returns to RUN. Restore-from-interrupt loads the whole register from a stacked byte. The set-mask and clear-mask commands drive the mask bit directly. A signed branch-condition output is derived from the negative, zero and overflow flags.

The sequencer states are RUN (normal operation), SAVE (register presented for stacking) and VECT (vector phase). It has three transitions: RUN to SAVE on an accepted request, SAVE to VECT unconditionally, and VECT to RUN unconditionally.

Top module: `alu_ccr`

## Requirements
- R1: While reset is asserted and after it is released, the register reads 0x68 (mask set, all flags clear), and both save_phase and vec_phase are 0.
- R2: Register bits 6 and 5 always read 1, including after a restore from a byte in which they are 0. The layout is V=bit7, H=bit4, I=bit3, N=bit2, Z=bit1, C=bit0.
- R3: Op code 0 (add) and op code 1 (add with the current C as carry-in) set C to the carry out of the top bit, H to the carry from bit 3 into bit 4, and V to signed overflow.
- R4: Op code 2 (subtract) and op code 3 (subtract with the current C as borrow-in) set C when a borrow is needed and set V on signed overflow. They leave H unchanged.
- R5: For every defined operation, N equals the top bit of the result and Z is 1 exactly when the result is zero.
- R6: Op codes 4 (AND), 5 (OR) and 6 (XOR) clear V and leave H and C unchanged.
- R7: Op codes 7 (shift left), 8 (shift right, zero fill), 9 (rotate left through C) and 10 (rotate right through C) operate on opa only. They set C to the bit shifted out and V to N xor C, and leave H unchanged.
- R8: The clear-mask command clears I in one cycle and the set-mask command sets I in one cycle. I is cleared by no other means than the clear-mask command and a restore.
- R9: A request is ignored while I is 1.
- R10: When a request is accepted in RUN with I clear, that cycle's operation is dropped. The next cycle is SAVE, with the register unchanged. The cycle after that is VECT, with I set. Then the sequencer returns to RUN. Operations, mask commands and restores are ignored during SAVE and VECT.
- R11: A restore in RUN loads the stacked byte, with bits 6 and 5 forced to 1. It takes priority over a same-cycle operation and a same-cycle request.
- R12: The branch output follows br_sel, where 0 is greater-than !(Z or (N xor V)), 1 is greater-or-equal !(N xor V), 2 is less-or-equal Z or (N xor V), and 3 is less-than N xor V.
- R13: With op_valid low, or with an op code from 11 to 15, the flags do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Apply the operation on this edge |
| op_sel | input | 4 | Operation code |
| opa | input | DW | First operand (minuend; the shift source) |
| opb | input | DW | Second operand |
| result | output | DW | Combinational operation result |
| sei_cmd | input | 1 | Set-mask command |
| cli_cmd | input | 1 | Clear-mask command |
| irq_req | input | 1 | Maskable interrupt request |
| rti_valid | input | 1 | Restore the register from rti_byte |
| rti_byte | input | 8 | Stacked register byte |
| br_sel | input | 2 | Signed branch condition select |
| ccr_out | output | 8 | Packed register value |
| save_phase | output | 1 | High in the SAVE state |
| vec_phase | output | 1 | High in the VECT state |
| br_taken | output | 1 | Selected branch condition is true |

## Verification
The hardest situation to create is interrupt entry while other commands compete for the register. Entry is reachable only once the mask is clear, and the SAVE and VECT windows each last a single cycle. The bench first clears the mask with a restore. It then raises a request together with a flag-changing operation. During SAVE it presents a restore of 0xFF, and during VECT it presents a clear-mask command. Each phase's register value is checked.

All eight combinations of N, Z and V are loaded through restores so that every branch condition is swept. The arithmetic sweeps run every opa value against a strided range of opb values.

// File: rtl/alu_ccr_pkg.sv
package alu_ccr_pkg;
    localparam int CCR_W = 8;
    localparam int BIT_V = 7;
    localparam int BIT_H = 4;
    localparam int BIT_I = 3;
    localparam int BIT_N = 2;
    localparam int BIT_Z = 1;
    localparam int BIT_C = 0;
    localparam logic [CCR_W-1:0] FIXED_ONES = 8'h60;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBC = 4'd3,
        OP_AND = 4'd4,
        OP_OR  = 4'd5,
        OP_XOR = 4'd6,
        OP_SHL = 4'd7,
        OP_SHR = 4'd8,
        OP_ROL = 4'd9,
        OP_ROR = 4'd10
    } alu_op_e;

    typedef enum logic [1:0] {
        SEQ_RUN  = 2'd0,
        SEQ_SAVE = 2'd1,
        SEQ_VECT = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        BR_GT = 2'd0,
        BR_GE = 2'd1,
        BR_LE = 2'd2,
        BR_LT = 2'd3
    } br_sel_e;

    typedef struct packed {
        logic v;
        logic h;
        logic n;
        logic z;
        logic c;
    } flags_t;
endpackage

// File: rtl/alu_core.sv
module alu_core
    import alu_ccr_pkg::*;
#(
    parameter int DW = 8
) (
    input  alu_op_e       op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          c_in,
    output logic [DW-1:0] y,
    output flags_t        nf,
    output flags_t        we
);
    localparam int HB = DW / 2;

    logic [DW:0] wide;
    logic [HB:0] low;
    logic [DW:0] cin_w;
    logic [HB:0] cin_l;

    always_comb begin
        y     = '0;
        nf    = '0;
        we    = '0;
        wide  = '0;
        low   = '0;
        cin_w = {{DW{1'b0}}, c_in};
        cin_l = {{HB{1'b0}}, c_in};
        case (op)
            OP_ADD, OP_ADC: begin
                wide = {1'b0, a} + {1'b0, b} + ((op == OP_ADC) ? cin_w : '0);
                low  = {1'b0, a[HB-1:0]} + {1'b0, b[HB-1:0]} + ((op == OP_ADC) ? cin_l : '0);
                y    = wide[DW-1:0];
                nf.c = wide[DW];
                nf.h = low[HB];
                nf.v = (a[DW-1] == b[DW-1]) && (y[DW-1] != a[DW-1]);
                we   = '1;
            end
            OP_SUB, OP_SBC: begin
                wide = {1'b0, a} - {1'b0, b} - ((op == OP_SBC) ? cin_w : '0);
                y    = wide[DW-1:0];
                nf.c = wide[DW];
                nf.v = (a[DW-1] != b[DW-1]) && (y[DW-1] != a[DW-1]);
                we   = '1;
                we.h = 1'b0;
            end
            OP_AND, OP_OR, OP_XOR: begin
                if (op == OP_AND)     y = a & b;
                else if (op == OP_OR) y = a | b;
                else                  y = a ^ b;
                nf.v = 1'b0;
                we.v = 1'b1;
                we.n = 1'b1;
                we.z = 1'b1;
            end
            OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
                if (op == OP_SHL) begin
                    y    = {a[DW-2:0], 1'b0};
                    nf.c = a[DW-1];
                end else if (op == OP_ROL) begin
                    y    = {a[DW-2:0], c_in};
                    nf.c = a[DW-1];
                end else if (op == OP_SHR) begin
                    y    = {1'b0, a[DW-1:1]};
                    nf.c = a[0];
                end else begin
                    y    = {c_in, a[DW-1:1]};
                    nf.c = a[0];
                end
                nf.v = y[DW-1] ^ nf.c;
                we   = '1;
                we.h = 1'b0;
            end
            default: begin
                y  = '0;
                we = '0;
            end
        endcase
        nf.n = y[DW-1];
        nf.z = ~|y;
    end
endmodule

// File: rtl/irq_seq.sv
module irq_seq
    import alu_ccr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_req,
    input  logic i_mask,
    input  logic rti_valid,
    output logic run_ok,
    output logic rti_ok,
    output logic entry_set,
    output logic save_phase,
    output logic vec_phase
);
    seq_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SEQ_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SEQ_RUN:  state_nx = (irq_req && !i_mask && !rti_valid) ? SEQ_SAVE : SEQ_RUN;
            SEQ_SAVE: state_nx = SEQ_VECT;
            SEQ_VECT: state_nx = SEQ_RUN;
            default:  state_nx = SEQ_RUN;
        endcase
    end

    always_comb begin
        run_ok     = 1'b0;
        rti_ok     = 1'b0;
        entry_set  = 1'b0;
        save_phase = 1'b0;
        vec_phase  = 1'b0;
        unique case (state)
            SEQ_RUN: begin
                rti_ok = rti_valid;
                run_ok = !rti_valid && (state_nx == SEQ_RUN);
            end
            SEQ_SAVE: begin
                save_phase = 1'b1;
                entry_set  = 1'b1;
            end
            SEQ_VECT: vec_phase = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/ccr_reg.sv
module ccr_reg
    import alu_ccr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  flags_t           nf,
    input  flags_t           we,
    input  logic             sei_en,
    input  logic             cli_en,
    input  logic             entry_set,
    input  logic             rti_load,
    input  logic [CCR_W-1:0] rti_byte,
    output logic [CCR_W-1:0] ccr
);
    logic v_q, h_q, i_q, n_q, z_q, c_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_q <= 1'b0;
            h_q <= 1'b0;
            i_q <= 1'b1;
            n_q <= 1'b0;
            z_q <= 1'b0;
            c_q <= 1'b0;
        end else if (rti_load) begin
            v_q <= rti_byte[BIT_V];
            h_q <= rti_byte[BIT_H];
            i_q <= rti_byte[BIT_I];
            n_q <= rti_byte[BIT_N];
            z_q <= rti_byte[BIT_Z];
            c_q <= rti_byte[BIT_C];
        end else if (entry_set) begin
            i_q <= 1'b1;
        end else begin
            if (upd) begin
                if (we.v) v_q <= nf.v;
                if (we.h) h_q <= nf.h;
                if (we.n) n_q <= nf.n;
                if (we.z) z_q <= nf.z;
                if (we.c) c_q <= nf.c;
            end
            if (sei_en)      i_q <= 1'b1;
            else if (cli_en) i_q <= 1'b0;
        end
    end

    assign ccr = FIXED_ONES | {v_q, 2'b00, h_q, i_q, n_q, z_q, c_q};
endmodule

// File: rtl/branch_eval.sv
module branch_eval
    import alu_ccr_pkg::*;
(
    input  logic [1:0] sel,
    input  logic       n,
    input  logic       z,
    input  logic       v,
    output logic       taken
);
    logic lt;

    always_comb begin
        lt = n ^ v;
        unique case (br_sel_e'(sel))
            BR_GT:   taken = !(z || lt);
            BR_GE:   taken = !lt;
            BR_LE:   taken = z || lt;
            BR_LT:   taken = lt;
            default: taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_ccr.sv
module alu_ccr
    import alu_ccr_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [3:0]    op_sel,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    output logic [DW-1:0] result,
    input  logic          sei_cmd,
    input  logic          cli_cmd,
    input  logic          irq_req,
    input  logic          rti_valid,
    input  logic [7:0]    rti_byte,
    input  logic [1:0]    br_sel,
    output logic [7:0]    ccr_out,
    output logic          save_phase,
    output logic          vec_phase,
    output logic          br_taken
);
    flags_t nf, we;
    logic   run_ok, rti_ok, entry_set;

    alu_core #(.DW(DW)) u_alu (
        .op   (alu_op_e'(op_sel)),
        .a    (opa),
        .b    (opb),
        .c_in (ccr_out[BIT_C]),
        .y    (result),
        .nf   (nf),
        .we   (we)
    );

    irq_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_req    (irq_req),
        .i_mask     (ccr_out[BIT_I]),
        .rti_valid  (rti_valid),
        .run_ok     (run_ok),
        .rti_ok     (rti_ok),
        .entry_set  (entry_set),
        .save_phase (save_phase),
        .vec_phase  (vec_phase)
    );

    ccr_reg u_ccr (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd       (op_valid && run_ok),
        .nf        (nf),
        .we        (we),
        .sei_en    (sei_cmd && run_ok),
        .cli_en    (cli_cmd && run_ok),
        .entry_set (entry_set),
        .rti_load  (rti_ok),
        .rti_byte  (rti_byte),
        .ccr       (ccr_out)
    );

    branch_eval u_br (
        .sel   (br_sel),
        .n     (ccr_out[BIT_N]),
        .z     (ccr_out[BIT_Z]),
        .v     (ccr_out[BIT_V]),
        .taken (br_taken)
    );
endmodule

// File: rtl/alu_ccr_chk.sv
module alu_ccr_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       op_valid,
    input logic [3:0] op_sel,
    input logic       irq_req,
    input logic       rti_valid,
    input logic       cli_cmd,
    input logic [7:0] ccr_out,
    input logic       save_phase,
    input logic       vec_phase
);
    // R9: masked request never starts entry
    a_r9_masked_no_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (!save_phase && !vec_phase && ccr_out[3]) |=> !save_phase);

    // R10: SAVE is followed by VECT with the mask set
    a_r10_save_to_vect: assert property (@(posedge clk) disable iff (!rst_n)
        save_phase |=> (vec_phase && ccr_out[3]));

    // R10: VECT returns to RUN
    a_r10_vect_to_run: assert property (@(posedge clk) disable iff (!rst_n)
        vec_phase |=> (!vec_phase && !save_phase));

    // R10: flags frozen across SAVE
    a_r10_save_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        save_phase |=> ($stable(ccr_out[7:4]) && $stable(ccr_out[2:0])));

    // R8: mask falls only by clear-mask or restore
    a_r8_mask_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ccr_out[3]) |-> $past(cli_cmd || rti_valid));

    // R6: logic ops keep H and C, clear V
    a_r6_logic_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel >= 4'd4 && op_sel <= 4'd6 && !save_phase && !vec_phase
         && !rti_valid && !(irq_req && !ccr_out[3]))
        |=> ($stable(ccr_out[4]) && $stable(ccr_out[0]) && !ccr_out[7]));
endmodule

bind alu_ccr alu_ccr_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_sel     (op_sel),
    .irq_req    (irq_req),
    .rti_valid  (rti_valid),
    .cli_cmd    (cli_cmd),
    .ccr_out    (ccr_out),
    .save_phase (save_phase),
    .vec_phase  (vec_phase)
);

// File: tb/alu_ccr_test.sv
module alu_ccr_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       op_valid, sei_cmd, cli_cmd, irq_req, rti_valid;
    logic [3:0] op_sel;
    logic [7:0] opa, opb, rti_byte, result, ccr_out;
    logic [1:0] br_sel;
    logic       save_phase, vec_phase, br_taken;

    int total = 0;
    int bad = 0;
    logic [7:0] m_ccr;

    always #10 clk = ~clk;

    alu_ccr uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .opa(opa), .opb(opb), .result(result), .sei_cmd(sei_cmd),
        .cli_cmd(cli_cmd), .irq_req(irq_req), .rti_valid(rti_valid),
        .rti_byte(rti_byte), .br_sel(br_sel), .ccr_out(ccr_out),
        .save_phase(save_phase), .vec_phase(vec_phase), .br_taken(br_taken)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model(input int op, input int a, input int b,
                         output int y, output logic [7:0] nx);
        int c, sa, sb, ss, full;
        logic cf, vf, hf;
        c  = int'(m_ccr[0]);
        sa = (a > 127) ? a - 256 : a;
        sb = (b > 127) ? b - 256 : b;
        nx = m_ccr;
        cf = m_ccr[0]; vf = m_ccr[7]; hf = m_ccr[4];
        y  = 0;
        if (op <= 1) begin
            if (op == 0) c = 0;
            full = a + b + c;
            y  = full % 256;
            cf = (full > 255);
            hf = ((a % 16) + (b % 16) + c) > 15;
            ss = sa + sb + c;
            vf = (ss > 127) || (ss < -128);
        end else if (op <= 3) begin
            if (op == 2) c = 0;
            full = a - b - c;
            y  = (full + 512) % 256;
            cf = (full < 0);
            ss = sa - sb - c;
            vf = (ss > 127) || (ss < -128);
        end else if (op <= 6) begin
            if (op == 4)      y = a & b;
            else if (op == 5) y = a | b;
            else              y = a ^ b;
            vf = 1'b0;
        end else if (op <= 10) begin
            if (op == 7)      begin y = (a * 2) % 256;         cf = (a > 127); end
            else if (op == 9) begin y = (a * 2 + c) % 256;     cf = (a > 127); end
            else if (op == 8) begin y = a / 2;                 cf = (a % 2) == 1; end
            else              begin y = a / 2 + c * 128;       cf = (a % 2) == 1; end
            vf = (y > 127) ^ cf;
        end
        if (op <= 10) begin
            nx[7] = vf; nx[4] = hf; nx[0] = cf;
            nx[2] = (y > 127);
            nx[1] = (y == 0);
        end
    endtask

    task automatic do_op(input int op, input int a, input int b, input string tag);
        int y;
        logic [7:0] nx;
        @(negedge clk);
        op_valid = 1'b1; op_sel = 4'(op); opa = 8'(a); opb = 8'(b);
        model(op, a, b, y, nx);
        #5;
        if (op <= 10) chk({tag, " result"}, result, 8'(y));
        @(posedge clk); #1;
        chk({tag, " ccr"}, ccr_out, nx);
        m_ccr = nx;
    endtask

    task automatic do_rti(input logic [7:0] v);
        @(negedge clk);
        rti_valid = 1'b1; rti_byte = v;
        @(posedge clk); #1;
        rti_valid = 1'b0;
        m_ccr = v | 8'h60;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        string tg;
        rst_n = 1'b0; op_valid = 0; sei_cmd = 0; cli_cmd = 0; irq_req = 0;
        rti_valid = 0; op_sel = 0; opa = 0; opb = 0; rti_byte = 0; br_sel = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 ccr in reset", ccr_out, 8'h68);
        chk("R1 phases in reset", {6'd0, save_phase, vec_phase}, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 ccr after reset", ccr_out, 8'h68);
        m_ccr = 8'h68;

        // R9: request while masked
        @(negedge clk); irq_req = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); #1;
            chk("R9 masked request ignored", {6'd0, save_phase, vec_phase}, 8'h00);
        end
        @(negedge clk); irq_req = 1'b0;

        // R8: mask commands
        @(negedge clk); cli_cmd = 1'b1;
        @(posedge clk); #1; cli_cmd = 1'b0;
        chk("R8 clear mask", ccr_out, 8'h60);
        @(negedge clk); sei_cmd = 1'b1;
        @(posedge clk); #1; sei_cmd = 1'b0;
        chk("R8 set mask", ccr_out, 8'h68);
        m_ccr = 8'h68;

        // R3 R4 R5 sweeps
        for (int op = 0; op < 4; op++)
            for (int a = 0; a < 256; a++)
                for (int b = 0; b < 256; b += 5) begin
                    tg = (op < 2) ? "R3/R5" : "R4/R5";
                    do_op(op, a, b, tg);
                end
        // R6 logic
        for (int op = 4; op < 7; op++)
            for (int a = 0; a < 256; a++)
                for (int b = 0; b < 256; b += 17)
                    do_op(op, a, b, "R6/R5");
        // R7 shifts and rotates
        for (int op = 7; op < 11; op++)
            for (int a = 0; a < 256; a++)
                do_op(op, a, (a * 7) % 256, "R7/R5");

        // R13: op_valid low, and undefined codes
        do_rti(8'h08);
        @(negedge clk); op_valid = 1'b0; op_sel = 4'd0; opa = 8'hFF; opb = 8'h01;
        @(posedge clk); #1;
        chk("R13 op_valid low", ccr_out, 8'h68);
        do_op(12, 255, 1, "R13 undefined code");
        do_op(15, 0, 0, "R13 undefined code");
        @(negedge clk); op_valid = 1'b0;

        // R11 / R2: restore
        do_rti(8'h00);
        chk("R11/R2 restore zero byte", ccr_out, 8'h60);
        do_rti(8'hFF);
        chk("R11 restore all ones", ccr_out, 8'hFF);
        @(negedge clk);
        rti_valid = 1'b1; rti_byte = 8'h81; op_valid = 1'b1; op_sel = 4'd0; opa = 0; opb = 0;
        @(posedge clk); #1;
        rti_valid = 1'b0; op_valid = 1'b0;
        chk("R11 restore beats operation", ccr_out, 8'hE1);

        // R12: branch conditions over N,Z,V
        for (int k = 0; k < 8; k++) begin
            logic n, z, v, lt;
            n = k[0]; z = k[1]; v = k[2]; lt = n ^ v;
            do_rti({v, 4'b0000, n, z, 1'b0});
            for (int s = 0; s < 4; s++) begin
                logic e;
                br_sel = 2'(s);
                #1;
                case (s)
                    0: e = !(z | lt);
                    1: e = !lt;
                    2: e = z | lt;
                    default: e = lt;
                endcase
                chk("R12 branch", {7'd0, br_taken}, {7'd0, e});
            end
        end

        // R10: entry sequence with competing commands
        do_rti(8'h00);
        @(negedge clk);
        irq_req = 1'b1; op_valid = 1'b1; op_sel = 4'd0; opa = 8'h7F; opb = 8'h01;
        @(posedge clk); #1;
        chk("R10 SAVE phase", {6'd0, save_phase, vec_phase}, 8'h02);
        chk("R10 SAVE ccr unchanged", ccr_out, 8'h60);
        @(negedge clk); rti_valid = 1'b1; rti_byte = 8'hFF;
        @(posedge clk); #1;
        chk("R10 VECT phase", {6'd0, save_phase, vec_phase}, 8'h01);
        chk("R10 VECT mask set", ccr_out, 8'h68);
        @(negedge clk); rti_valid = 1'b0; cli_cmd = 1'b1;
        @(posedge clk); #1;
        chk("R10 back to RUN", {6'd0, save_phase, vec_phase}, 8'h00);
        chk("R10 clear mask ignored in VECT", ccr_out, 8'h68);
        @(negedge clk); cli_cmd = 1'b0; op_valid = 1'b0;
        @(posedge clk); #1;
        chk("R9 no re-entry with mask set", {6'd0, save_phase, vec_phase}, 8'h00);
        @(negedge clk); irq_req = 1'b0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule